// File: doc/BRIEF.md
# Phase Edge Timestamp Capture

This block measures the period or duty cycle of one encoder phase input. When capture operation is selected and the block is enabled, it watches either phase A or phase B, picks out the transitions chosen by the edge configuration and stamps each one with the value of a free-running counter. The stamps queue in a small FIFO that software drains one entry per pop strobe. The difference between two consecutive stamps gives the period, or the high or low time when both edges are captured.

The timestamp counter does not run on the main clock directly. A post-scaler divides the main clock by a power of two chosen through a 3-bit exponent, so slow inputs can be measured without the counter wrapping. Two event pulses report FIFO activity. One fires for every stored stamp. The other fires when the occupancy reaches a programmable threshold, which is written as the threshold minus one. The input select, the edge configuration and the operating mode are sampled only while the block is disabled, so a reconfiguration can never corrupt a measurement in progress.

Top module: `edge_stamp_capture`

## Requirements
- R1: `cfg_sel_b` = 0 makes only phase A transitions eligible, and `cfg_sel_b` = 1 makes only phase B transitions eligible. Transitions on the other phase store nothing.
- R2: With `cfg_both` = 0, only one transition direction is captured: rising edges when `cfg_rise` = 1, and falling edges when `cfg_rise` = 0.
- R3: With `cfg_both` = 1, both rising and falling transitions of the selected phase are captured.
- R4: The counter is held at 0 while the block is inactive. After m active clock edges it reads floor(m / 2^`cfg_div_exp`). The inputs pass through two synchroniser flops, so a transition set up before active edge k is stored with the counter value reached after edge k+1.
- R5: The FIFO holds 8 stamps and returns them oldest first. `rd_data` shows the oldest stamp, and a one-cycle `pop` removes it.
- R6: After reset, `fifo_empty` = 1, `rd_data` = 0, `fifo_overflow` = 0 and `evt_vec` = 0. While the FIFO is empty, `rd_data` is 0, and a `pop` changes neither the contents nor the flag.
- R7: `evt_vec` bit 4 pulses for one cycle, one clock after each stamp is stored.
- R8: `evt_vec` bit 5 pulses together with bit 4 when the store brings the occupancy to `cfg_thresh_m1` + 1. `evt_vec` bits 3 to 0 stay 0.
- R9: A qualifying edge that arrives while the FIFO is full is dropped and the stored stamps are kept. `fifo_overflow` is then set and stays set until the block becomes inactive.
- R10: `cfg_sel_b`, `cfg_both`, `cfg_rise` and `cfg_capture` are taken only while `cfg_en` = 0. Changing them while enabled has no effect.
- R11: With `cfg_capture` = 0 (quadrature operation selected), enabling the block captures nothing and raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable |
| cfg_capture | input | 1 | 1 selects capture operation, 0 selects quadrature operation |
| cfg_sel_b | input | 1 | Input select: 0 phase A, 1 phase B |
| cfg_both | input | 1 | 1 captures both edges, 0 captures a single edge |
| cfg_rise | input | 1 | Single-edge direction: 1 rising, 0 falling |
| cfg_div_exp | input | 3 | Post-scaler exponent n; the counter clock is the main clock divided by 2^n |
| cfg_thresh_m1 | input | 3 | FIFO critical threshold minus one |
| phase_a | input | 1 | Phase A input, asynchronous |
| phase_b | input | 1 | Phase B input, asynchronous |
| pop | input | 1 | Removes the oldest stamp |
| rd_data | output | 32 | Oldest stamp, or 0 when the FIFO is empty |
| fifo_empty | output | 1 | FIFO holds no stamp |
| fifo_overflow | output | 1 | Sticky flag: a capture was dropped because the FIFO was full |
| evt_vec | output | 6 | Event pulses: bit 4 stamp stored, bit 5 threshold reached |

## Verification
The bench predicts every stamp from its own count of active clock edges, the synchroniser delay and the divider exponent, including the largest exponent 7. A design that lost a synchroniser stage, or that ticked the divider on the wrong phase, would return stamps off by one counter step. It overfills the FIFO to check that the first eight stamps are kept and that the overflow flag sets and later clears. A FIFO that overwrote old data, or that let the flag decay on its own, would fail these checks. It also pops an empty FIFO and then captures once more: a design that moved its read pointer on the empty pop would return a stale or zero stamp. Finally, it changes the input select and the edge mode while the block is enabled, so a design that did not hold its configuration would capture the wrong phase or the wrong edge.

// File: rtl/cap_pkg.sv
package cap_pkg;
   // Configuration sampled while the block is disabled.
   typedef struct packed {
      logic capture;
      logic sel_b;
      logic both;
      logic rise;
   } cap_cfg_t;

   localparam int EVT_W       = 6;
   localparam int EVT_ENTRY   = 4;
   localparam int EVT_CRIT    = 5;
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] chain;
   logic              hist;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cap_edge_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist <= 1'b0;
      else        hist <= chain[STAGES-1];
   end

   assign rise = chain[STAGES-1] & ~hist;
   assign fall = ~chain[STAGES-1] & hist;
endmodule

// File: rtl/cap_timebase.sv
module cap_timebase #(
   parameter int TS_W  = 32,
   parameter int DIV_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_exp,
   output logic [TS_W-1:0]  stamp
);
   localparam int PRE_W = (DIV_W > 0) ? ((1 << DIV_W) - 1) : 1;

   logic tick;

   generate
      if (TS_W < 2) begin : g_bad_width
         $error("cap_timebase needs a wider counter");
      end
      if (DIV_W == 0) begin : g_no_scaler
         assign tick = 1'b1;
      end else begin : g_scaler
         logic [PRE_W-1:0] pre;
         logic [PRE_W-1:0] mask;
         assign mask = PRE_W'((1 << div_exp) - 1);
         assign tick = &(pre | ~mask);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    pre <= '0;
            else if (!run) pre <= '0;
            else           pre <= pre + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    stamp <= '0;
      else if (!run) stamp <= '0;
      else if (tick) stamp <= stamp + 1'b1;
   end
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       empty,
   output logic                       full,
   output logic [$clog2(DEPTH):0]     level
);
   localparam int AW = $clog2(DEPTH);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   generate
      if ((1 << AW) != DEPTH || DEPTH < 2) begin : g_bad_depth
         $error("cap_fifo depth must be a power of two of at least 2");
      end
   endgenerate

   assign empty   = (level == '0);
   assign full    = (level == (AW+1)'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture
   import cap_pkg::*;
#(
   parameter int TS_W        = 32,
   parameter int DEPTH       = 8,
   parameter int DIV_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_en,
   input  logic                     cfg_capture,
   input  logic                     cfg_sel_b,
   input  logic                     cfg_both,
   input  logic                     cfg_rise,
   input  logic [DIV_W-1:0]         cfg_div_exp,
   input  logic [$clog2(DEPTH)-1:0] cfg_thresh_m1,
   input  logic                     phase_a,
   input  logic                     phase_b,
   input  logic                     pop,
   output logic [TS_W-1:0]          rd_data,
   output logic                     fifo_empty,
   output logic                     fifo_overflow,
   output logic [EVT_W-1:0]         evt_vec
);
   localparam int AW = $clog2(DEPTH);

   cap_cfg_t            cfg_q;
   logic                active;
   logic                rise_a, fall_a, rise_b, fall_b;
   logic                sel_rise, sel_fall, hit;
   logic [TS_W-1:0]     stamp;
   logic                full;
   logic [AW:0]         level;
   logic                ev_entry_q, ev_crit_q, stored, reach;

   // Mode, select and edge fields are frozen while enabled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cfg_q <= '0;
      else if (!cfg_en) cfg_q <= '{capture: cfg_capture, sel_b: cfg_sel_b,
                                   both: cfg_both, rise: cfg_rise};
   end

   assign active = cfg_en & cfg_q.capture;

   cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
      .clk(clk), .rst_n(rst_n), .din(phase_a), .rise(rise_a), .fall(fall_a));
   cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
      .clk(clk), .rst_n(rst_n), .din(phase_b), .rise(rise_b), .fall(fall_b));

   assign sel_rise = cfg_q.sel_b ? rise_b : rise_a;
   assign sel_fall = cfg_q.sel_b ? fall_b : fall_a;
   assign hit      = active & (cfg_q.both ? (sel_rise | sel_fall)
                                          : (cfg_q.rise ? sel_rise : sel_fall));

   cap_timebase #(.TS_W(TS_W), .DIV_W(DIV_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .run(active), .div_exp(cfg_div_exp),
      .stamp(stamp));

   cap_fifo #(.W(TS_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(hit), .din(stamp), .pop(pop),
      .dout(rd_data), .empty(fifo_empty), .full(full), .level(level));

   assign stored = hit & ~full;
   assign reach  = (level == {1'b0, cfg_thresh_m1});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ev_entry_q    <= 1'b0;
         ev_crit_q     <= 1'b0;
         fifo_overflow <= 1'b0;
      end else begin
         ev_entry_q <= stored;
         ev_crit_q  <= stored & reach;
         if (!active)        fifo_overflow <= 1'b0;
         else if (hit & full) fifo_overflow <= 1'b1;
      end
   end

   always_comb begin
      evt_vec            = '0;
      evt_vec[EVT_ENTRY] = ev_entry_q;
      evt_vec[EVT_CRIT]  = ev_crit_q;
   end
endmodule

// File: rtl/edge_stamp_capture_chk.sv
module edge_stamp_capture_chk #(
   parameter int TS_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_en,
   input logic            active,
   input logic            fifo_empty,
   input logic            fifo_overflow,
   input logic [TS_W-1:0] rd_data,
   input logic [5:0]      evt_vec
);
   AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_empty |-> rd_data == '0); // R6
   AST_ENTRY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[4] |-> !fifo_empty); // R7
   AST_CRIT_WITH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[5] |-> evt_vec[4]); // R8
   AST_LOW_EVENTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[3:0] == 4'b0); // R8
   AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_overflow && active) |=> fifo_overflow); // R9
   AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> !evt_vec[4]); // R11
   AST_EMPTY_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !active) |=> fifo_empty); // R11
endmodule

bind edge_stamp_capture edge_stamp_capture_chk #(.TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .active(active),
   .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow),
   .rd_data(rd_data), .evt_vec(evt_vec));

// File: tb/edge_stamp_capture_tb.sv
module edge_stamp_capture_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_en = 1'b0, cfg_capture = 1'b0, cfg_sel_b = 1'b0;
   logic        cfg_both = 1'b0, cfg_rise = 1'b1;
   logic [2:0]  cfg_div_exp = 3'd0, cfg_thresh_m1 = 3'd7;
   logic        phase_a = 1'b0, phase_b = 1'b0, pop = 1'b0;
   logic [31:0] rd_data;
   logic        fifo_empty, fifo_overflow;
   logic [5:0]  evt_vec;

   int checks = 0, errors = 0;
   int act = 0, occ = 0;
   int n_entry = 0, n_crit = 0, bad_low = 0;
   bit finished = 0;
   logic m_cap = 0, m_sel = 0, m_both = 0, m_rise = 0;
   logic [31:0] expq[$];

   always #5 clk = ~clk;

   edge_stamp_capture u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_capture(cfg_capture),
      .cfg_sel_b(cfg_sel_b), .cfg_both(cfg_both), .cfg_rise(cfg_rise),
      .cfg_div_exp(cfg_div_exp), .cfg_thresh_m1(cfg_thresh_m1),
      .phase_a(phase_a), .phase_b(phase_b), .pop(pop), .rd_data(rd_data),
      .fifo_empty(fifo_empty), .fifo_overflow(fifo_overflow), .evt_vec(evt_vec));

   // Reference view of frozen configuration and active edge count
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cap <= 0; m_sel <= 0; m_both <= 0; m_rise <= 0; act = 0;
      end else begin
         if (!cfg_en) begin
            m_cap <= cfg_capture; m_sel <= cfg_sel_b;
            m_both <= cfg_both;   m_rise <= cfg_rise;
         end
         if (cfg_en && m_cap) act = act + 1; else act = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_vec[4]) n_entry++;
         if (evt_vec[5]) n_crit++;
         if (evt_vec[3:0] != 0) bad_low++;
      end
   end

   task automatic chk(string req, logic [31:0] actual, logic [31:0] expect_v);
      checks++;
      if (actual !== expect_v) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, actual, expect_v);
      end
   endtask

   // Driver: toggles one phase and predicts the stamp it yields
   task automatic tog(bit on_b, int gap);
      logic v;
      @(negedge clk);
      v = on_b ? ~phase_b : ~phase_a;
      if (on_b) phase_b = v; else phase_a = v;
      if (cfg_en && m_cap && (on_b == m_sel) && (m_both || (v == m_rise))) begin
         if (occ < 8) begin
            expq.push_back(32'((act + 2) >> cfg_div_exp));
            occ++;
         end
      end
      repeat (gap) @(negedge clk);
   endtask

   // Monitor: pops every stamp and compares with the queue
   task automatic drain(string req);
      while (!fifo_empty) begin
         @(negedge clk);
         if (expq.size() == 0) chk(req, rd_data, 32'hDEAD_BEEF);
         else chk(req, rd_data, expq.pop_front());
         pop = 1'b1;
         @(negedge clk);
         pop = 1'b0;
      end
      chk({req, " queue"}, expq.size(), 0);
      occ = 0;
   endtask

   task automatic start();
      @(negedge clk); cfg_en = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic stop();
      @(negedge clk); cfg_en = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int e0, c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R6 reset empty", fifo_empty, 1);
      chk("R6 reset data", rd_data, 0);
      chk("R6 reset ovf", fifo_overflow, 0);
      chk("R6 reset evt", evt_vec, 0);

      // R1 R2: phase A, rising only, divide by 1
      cfg_capture = 1; cfg_sel_b = 0; cfg_both = 0; cfg_rise = 1; cfg_div_exp = 0;
      start();
      e0 = n_entry;
      tog(0, 6); tog(1, 6); tog(0, 6); tog(0, 6); tog(1, 6); tog(0, 6);
      chk("R7 entry pulses", n_entry - e0, 2);
      drain("R1 R2 R5 A rising");
      stop();

      // R1 R2: phase B, falling only, divide by 4
      cfg_sel_b = 1; cfg_rise = 0; cfg_div_exp = 2;
      start();
      tog(1, 9); tog(0, 9); tog(1, 9); tog(1, 9); tog(0, 9); tog(1, 9);
      drain("R1 R2 R4 B falling");
      stop();

      // R3 R4: both edges, largest divider
      cfg_sel_b = 0; cfg_both = 1; cfg_div_exp = 7;
      start();
      repeat (300) @(negedge clk);
      tog(0, 250); tog(0, 300); tog(0, 130);
      drain("R3 R4 both div128");
      stop();

      // R8: threshold 3
      cfg_div_exp = 0; cfg_thresh_m1 = 2;
      start();
      e0 = n_entry; c0 = n_crit;
      tog(0, 5); tog(0, 5); tog(0, 5); tog(0, 5);
      chk("R8 crit pulses", n_crit - c0, 1);
      chk("R7 entry count", n_entry - e0, 4);
      drain("R8 stamps");

      // R6: pop on empty changes nothing
      @(negedge clk); pop = 1; @(negedge clk); pop = 0;
      chk("R6 empty pop data", rd_data, 0);
      chk("R6 empty pop flag", fifo_empty, 1);
      tog(0, 5);
      drain("R6 after empty pop");

      // R9: overflow keeps first eight
      e0 = n_entry;
      for (int i = 0; i < 10; i++) tog(0, 4);
      chk("R9 overflow set", fifo_overflow, 1);
      chk("R9 stored count", n_entry - e0, 8);
      drain("R9 kept oldest");
      chk("R9 sticky", fifo_overflow, 1);
      stop();
      chk("R9 cleared inactive", fifo_overflow, 0);

      // R10: config changes while enabled are ignored
      cfg_both = 0; cfg_rise = 1; cfg_sel_b = 0; cfg_thresh_m1 = 7;
      if (phase_a) tog(0, 3);
      start();
      @(negedge clk); cfg_sel_b = 1; cfg_both = 1;
      tog(1, 5); tog(1, 5);
      chk("R10 other phase ignored", fifo_empty, 1);
      tog(0, 5); tog(0, 5);
      drain("R10 frozen select and edge");
      stop();

      // R11: quadrature operation captures nothing
      cfg_capture = 0;
      start();
      e0 = n_entry;
      tog(0, 5); tog(0, 5); tog(1, 5); tog(1, 5);
      chk("R11 no capture", fifo_empty, 1);
      chk("R11 no event", n_entry - e0, 0);
      stop();

      chk("R8 low bits", bad_low, 0);
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule